// File: doc/BRIEF.md
# Trigger Matrix Configuration Port

This block is the configuration front end of a trigger matrix. The host reaches it through one 32-bit register. Each word written to that register carries three fields: a command code in the top nibble, a channel index in the byte below it, and a payload that is aligned to bit 0. From these commands the block keeps two kinds of setting. The first is one selection row for each of 18 trigger sources, and each row is a 17-bit mask of trace memories. The second is a single 16-bit aggregation window length. Both are presented as parallel outputs to the matching logic downstream.

Reading a setting back takes two steps. The host first writes a read command, which captures the chosen setting into a readback holder. A later host read then returns that captured value. The returned word holds the payload only and never the channel number.

Within a row, bit 0 selects the dummy memory and bit k+1 selects the trace memory of channel k. Rows 0 to 15 belong to the per-channel discriminators. Row 16 belongs to the global acquire trigger and row 17 to the global don't-acquire trigger.

Top module: `trig_cfg_port`

## Requirements
- R1: While `rst_n` is low at a rising edge, every row, the window length and `host_rd_data` are cleared to zero.
- R2: A write whose bits 31:28 equal 4'h1 and whose bits 27:20 hold an index below 18 loads bits 16:0 into that row. The new value is visible on `trig_rows` from the cycle after the write, and the other rows do not change.
- R3: A write whose bits 31:28 equal 4'h2 loads bits 15:0 into `win_len` from the cycle after the write. Bits 27:16 are ignored.
- R4: A write with code 4'h9 and a valid index captures that row, zero-extended to 32 bits, as the readback value. A store command does not change the captured readback. A returned word never carries the channel field, and bits 31:17 always read zero.
- R5: A write with code 4'hA captures the window length, zero-extended, as the readback value.
- R6: A row store (4'h1) or row read (4'h9) whose index in bits 27:20 is 18 or more changes no row and no window. It also clears the readback value to zero.
- R7: A write with any code other than 4'h1, 4'h2, 4'h9 or 4'hA changes no stored setting and clears the readback value to zero.
- R8: Bits 19:17 of a row store are ignored. Only the low 17 payload bits reach the row.
- R9: `host_rd_data` takes the readback value on the edge where `host_rd_en` is high and holds it otherwise. A read in the same cycle as a write returns the readback value from before that write.
- R10: Writing 0x10000007 sets row 0 to 0x00007, which selects the dummy memory and channels 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for the command register |
| host_wr_data | input | 32 | Host write word (code, channel, payload) |
| host_rd_en | input | 1 | Host read strobe for the command register |
| host_rd_data | output | 32 | Readback word, updated on a host read |
| trig_rows | output | 18x17 | Packed selection rows, one per trigger source |
| win_len | output | 16 | Aggregation window length in clock cycles |

## Verification
The hardest situation to reach from the ports is the ordering between the readback holder and the output register. Examples are a read strobe in the same cycle as a read command, a store placed between a read command and its read, and a rejected write that must wipe a capture that was non-zero before it. The bench builds each of these orderings on purpose, setting the readback to a known non-zero value before every rejected write. It also sweeps every channel index from 0 to 31, plus 255, and every one of the 16 command codes, so that each out-of-range index and each unknown code is exercised.

// File: rtl/trig_cfg_pkg.sv
// Package: shared command encodings and decoded-action type for the
// trigger matrix configuration port. Assumes a 4-bit command nibble.
package trig_cfg_pkg;

    localparam logic [3:0] CMD_PUT_ROW = 4'h1;
    localparam logic [3:0] CMD_PUT_WIN = 4'h2;
    localparam logic [3:0] CMD_GET_ROW = 4'h9;
    localparam logic [3:0] CMD_GET_WIN = 4'hA;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PUT_ROW,
        ACT_PUT_WIN,
        ACT_GET_ROW,
        ACT_GET_WIN,
        ACT_REJECT
    } act_e;

endpackage

// File: rtl/trig_cfg_decode.sv
// Module: trig_cfg_decode
// Turns the command nibble and channel byte of a host write into one
// action and a row index. Purely combinational. Assumes the caller only
// uses row_idx when the action is a row store or a row read.
module trig_cfg_decode
    import trig_cfg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 18,
    parameter int unsigned CH_W    = 8,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic             wr_en,
    input  logic [3:0]       cmd,
    input  logic [CH_W-1:0]  chan,
    output act_e             act,
    output logic [IDX_W-1:0] row_idx
);

    logic chan_ok;

    // Check the channel byte against the number of rows.
    always_comb begin
        chan_ok = (32'(chan) < NUM_SRC);
        row_idx = chan[IDX_W-1:0];
    end

    // Map command nibble and channel validity onto one action.
    always_comb begin
        act = ACT_IDLE;
        if (wr_en) begin
            unique case (cmd)
                CMD_PUT_ROW: act = chan_ok ? ACT_PUT_ROW : ACT_REJECT;
                CMD_GET_ROW: act = chan_ok ? ACT_GET_ROW : ACT_REJECT;
                CMD_PUT_WIN: act = ACT_PUT_WIN;
                CMD_GET_WIN: act = ACT_GET_WIN;
                default:     act = ACT_REJECT;
            endcase
        end
    end

endmodule

// File: rtl/trig_cfg_rowbank.sv
// Module: trig_cfg_rowbank
// Holds one selection row per trigger source. A single write port loads
// the addressed row. Assumes idx is in range whenever we is high.
module trig_cfg_rowbank #(
    parameter int unsigned NUM_SRC = 18,
    parameter int unsigned ROW_W   = 17,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                idx,
    input  logic [ROW_W-1:0]                din,
    output logic [NUM_SRC-1:0][ROW_W-1:0]   rows
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_row
        // Load this row when it is the one addressed by the write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rows[g] <= '0;
            else if (we && (32'(idx) == g))
                rows[g] <= din;
        end
    end

endmodule

// File: rtl/trig_cfg_winreg.sv
// Module: trig_cfg_winreg
// Holds the aggregation window length, loaded from the payload field.
// Assumes the payload arrives right-aligned.
module trig_cfg_winreg #(
    parameter int unsigned WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIN_W-1:0] din,
    output logic [WIN_W-1:0] win
);

    // Capture a new window length on a window store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win <= '0;
        else if (we)
            win <= din;
    end

endmodule

// File: rtl/trig_cfg_readback.sv
// Module: trig_cfg_readback
// Two-step readback. A read command captures the chosen setting into a
// holder and a rejected write clears it. A host read copies the holder
// to the output word. Assumes ROW_W and WIN_W fit within DATA_W.
module trig_cfg_readback
    import trig_cfg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 18,
    parameter int unsigned ROW_W   = 17,
    parameter int unsigned WIN_W   = 16,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  act_e                            act,
    input  logic [IDX_W-1:0]                row_idx,
    input  logic [NUM_SRC-1:0][ROW_W-1:0]   rows,
    input  logic [WIN_W-1:0]                win,
    input  logic                            rd_en,
    output logic [DATA_W-1:0]               rd_data
);

    logic [DATA_W-1:0] held_q;
    logic [DATA_W-1:0] held_d;

    // Choose the next holder value from the decoded action.
    always_comb begin
        held_d = held_q;
        case (act)
            ACT_GET_ROW: held_d = {{(DATA_W-ROW_W){1'b0}}, rows[row_idx]};
            ACT_GET_WIN: held_d = {{(DATA_W-WIN_W){1'b0}}, win};
            ACT_REJECT:  held_d = '0;
            default:     held_d = held_q;
        endcase
    end

    // Register the readback holder.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else
            held_q <= held_d;
    end

    // Present the holder to the host on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= held_q;
    end

endmodule

// File: rtl/trig_cfg_port.sv
// Module: trig_cfg_port (top)
// Configuration port of the trigger matrix, reached through one host
// register. It splits each write into command, channel and payload, stores
// the rows and the window length, and serves two-step readback. Assumes
// the host bus protocol has already been reduced to write and read strobes.
module trig_cfg_port
    import trig_cfg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 18,
    parameter int unsigned ROW_W   = 17,
    parameter int unsigned WIN_W   = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CH_W    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_wr_en,
    input  logic [DATA_W-1:0]               host_wr_data,
    input  logic                            host_rd_en,
    output logic [DATA_W-1:0]               host_rd_data,
    output logic [NUM_SRC-1:0][ROW_W-1:0]   trig_rows,
    output logic [WIN_W-1:0]                win_len
);

    localparam int unsigned IDX_W  = $clog2(NUM_SRC);
    localparam int unsigned CMD_LO = DATA_W - 4;
    localparam int unsigned CH_LO  = CMD_LO - CH_W;

    act_e             act;
    logic [IDX_W-1:0] row_idx;

    trig_cfg_decode #(
        .NUM_SRC (NUM_SRC),
        .CH_W    (CH_W)
    ) u_decode (
        .wr_en   (host_wr_en),
        .cmd     (host_wr_data[DATA_W-1:CMD_LO]),
        .chan    (host_wr_data[CMD_LO-1:CH_LO]),
        .act     (act),
        .row_idx (row_idx)
    );

    trig_cfg_rowbank #(
        .NUM_SRC (NUM_SRC),
        .ROW_W   (ROW_W)
    ) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (act == ACT_PUT_ROW),
        .idx   (row_idx),
        .din   (host_wr_data[ROW_W-1:0]),
        .rows  (trig_rows)
    );

    trig_cfg_winreg #(
        .WIN_W (WIN_W)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (act == ACT_PUT_WIN),
        .din   (host_wr_data[WIN_W-1:0]),
        .win   (win_len)
    );

    trig_cfg_readback #(
        .NUM_SRC (NUM_SRC),
        .ROW_W   (ROW_W),
        .WIN_W   (WIN_W),
        .DATA_W  (DATA_W)
    ) u_rdbk (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .row_idx (row_idx),
        .rows    (trig_rows),
        .win     (win_len),
        .rd_en   (host_rd_en),
        .rd_data (host_rd_data)
    );

endmodule

// File: rtl/trig_cfg_port_chk.sv
// Module: trig_cfg_port_chk
// Port-level properties of trig_cfg_port, attached with bind below.
module trig_cfg_port_chk #(
    parameter int unsigned NUM_SRC = 18,
    parameter int unsigned ROW_W   = 17,
    parameter int unsigned WIN_W   = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CH_W    = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            host_wr_en,
    input logic [DATA_W-1:0]               host_wr_data,
    input logic                            host_rd_en,
    input logic [DATA_W-1:0]               host_rd_data,
    input logic [NUM_SRC-1:0][ROW_W-1:0]   trig_rows,
    input logic [WIN_W-1:0]                win_len
);

    localparam int unsigned IDX_W  = $clog2(NUM_SRC);
    localparam int unsigned CMD_LO = DATA_W - 4;
    localparam int unsigned CH_LO  = CMD_LO - CH_W;

    logic [3:0]       c_cmd;
    logic [CH_W-1:0]  c_ch;
    logic             c_ch_ok;
    logic             c_known;
    logic             c_rowcmd;

    // Independent field extraction from the host word.
    always_comb begin
        c_cmd    = host_wr_data[DATA_W-1:CMD_LO];
        c_ch     = host_wr_data[CMD_LO-1:CH_LO];
        c_ch_ok  = (32'(c_ch) < NUM_SRC);
        c_known  = (c_cmd == 4'h1) || (c_cmd == 4'h2) ||
                   (c_cmd == 4'h9) || (c_cmd == 4'hA);
        c_rowcmd = (c_cmd == 4'h1) || (c_cmd == 4'h9);
    end

    // R1: reset clears every output
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (trig_rows == '0 && win_len == '0 && host_rd_data == '0));

    // R2: row store lands in the addressed row
    p_row_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && c_cmd == 4'h1 && c_ch_ok) |=>
        trig_rows[$past(c_ch[IDX_W-1:0])] == $past(host_wr_data[ROW_W-1:0]));

    // R3: window store
    p_win_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && c_cmd == 4'h2) |=> win_len == $past(host_wr_data[WIN_W-1:0]));

    // R4: no channel field in returned words
    p_no_chan_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_data[DATA_W-1:ROW_W] == '0);

    // R6: out-of-range row index changes nothing
    p_bad_chan_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && c_rowcmd && !c_ch_ok) |=> ($stable(trig_rows) && $stable(win_len)));

    // R7: unknown code changes nothing
    p_bad_cmd_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !c_known) |=> ($stable(trig_rows) && $stable(win_len)));

    // R7: a rejected write followed by a lone read returns zero
    p_bad_cmd_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !c_known) ##1 (host_rd_en && !host_wr_en) |=> host_rd_data == '0);

    // R9: output holds without a read strobe
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |=> $stable(host_rd_data));

endmodule

bind trig_cfg_port trig_cfg_port_chk #(
    .NUM_SRC (NUM_SRC),
    .ROW_W   (ROW_W),
    .WIN_W   (WIN_W),
    .DATA_W  (DATA_W),
    .CH_W    (CH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .trig_rows    (trig_rows),
    .win_len      (win_len)
);

// File: tb/trig_cfg_port_bench.sv
// Bench: sweeps channel indices and command codes on trig_cfg_port and
// compares against a model built from the requirements.
module trig_cfg_port_bench;

    localparam int NS = 18;
    localparam int RW = 17;
    localparam int WW = 16;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   host_wr_en;
    logic [31:0]            host_wr_data;
    logic                   host_rd_en;
    logic [31:0]            host_rd_data;
    logic [NS-1:0][RW-1:0]  trig_rows;
    logic [WW-1:0]          win_len;

    int n_chk = 0;
    int n_bad = 0;
    logic [RW-1:0] exp_rows [NS];
    logic [WW-1:0] exp_win;

    always #4 clk = ~clk;

    trig_cfg_port u_trig_cfg_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_en   (host_rd_en),
        .host_rd_data (host_rd_data),
        .trig_rows    (trig_rows),
        .win_len      (win_len)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        for (int r = 0; r < NS; r++)
            check(req, 32'(trig_rows[r]), 32'(exp_rows[r]));
        check(req, 32'(win_len), 32'(exp_win));
    endtask

    task automatic wr(logic [31:0] w);
        @(negedge clk);
        host_wr_en   = 1'b1;
        host_wr_data = w;
        @(negedge clk);
        host_wr_en   = 1'b0;
    endtask

    task automatic rd(output logic [31:0] v);
        @(negedge clk);
        host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        v = host_rd_data;
    endtask

    function automatic logic [RW-1:0] pat(int ch);
        return RW'((ch * 32'h2F1B + 32'h155) ^ (ch << 9));
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        logic [WW-1:0] wins [5];
        rst_n = 1'b0;
        host_wr_en = 1'b0;
        host_wr_data = '0;
        host_rd_en = 1'b0;
        for (int r = 0; r < NS; r++) exp_rows[r] = '0;
        exp_win = '0;
        repeat (3) @(negedge clk);
        check_state("R1 reset");
        check("R1 rd_data reset", host_rd_data, 32'h0);
        rst_n = 1'b1;

        // R10: example word
        wr(32'h1000_0007);
        exp_rows[0] = 17'h00007;
        check("R10 example row0", 32'(trig_rows[0]), 32'h7);

        // R2 / R6 / R8: store sweep over indices 0..31 and 255
        for (int ch = 0; ch <= 32; ch++) begin
            int c;
            c = (ch == 32) ? 255 : ch;
            wr({4'h1, 8'(c), 3'b101, pat(c)});
            if (c < NS) exp_rows[c] = pat(c);
            check_state((c < NS) ? "R2 R8 row store" : "R6 bad index store");
        end

        // R4 / R6: read sweep over the same indices
        for (int ch = 0; ch <= 32; ch++) begin
            int c;
            c = (ch == 32) ? 255 : ch;
            wr({4'h9, 8'(c), 20'hABCDE});
            check_state("R4 R6 read command inert");
            rd(v);
            check((c < NS) ? "R4 row readback" : "R6 bad index reads zero",
                  v, (c < NS) ? 32'(exp_rows[c]) : 32'h0);
        end

        // R3 / R5: window values with noise in bits 27:16
        wins[0] = 16'h0000; wins[1] = 16'h0001; wins[2] = 16'h0005;
        wins[3] = 16'hFFFF; wins[4] = 16'h8001;
        for (int i = 0; i < 5; i++) begin
            wr({4'h2, 12'hABC, wins[i]});
            exp_win = wins[i];
            check_state("R3 window store");
            wr({4'hA, 12'h5A5, 16'h1234});
            rd(v);
            check("R5 window readback", v, 32'(wins[i]));
        end

        // R7: every unknown code, with a non-zero capture before it
        for (int op = 0; op < 16; op++) begin
            if (op == 1 || op == 2 || op == 9 || op == 10) continue;
            wr({4'hA, 28'h0});
            wr({4'(op), 8'h02, 20'hFFFFF});
            check_state("R7 unknown code inert");
            rd(v);
            check("R7 unknown code reads zero", v, 32'h0);
        end

        // R4: a store between read command and read leaves the capture
        wr({4'h9, 8'd3, 20'h0});
        wr({4'h1, 8'd5, 3'b000, 17'h1_5A5A});
        exp_rows[5] = 17'h1_5A5A;
        rd(v);
        check("R4 store keeps capture", v, 32'(exp_rows[3]));
        held = v;

        // R9: hold without strobe, then read in the same cycle as a write
        repeat (3) @(negedge clk);
        check("R9 hold idle", host_rd_data, held);
        wr({4'h9, 8'd16, 20'h0});
        check("R9 hold after command", host_rd_data, held);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_wr_data = {4'hA, 28'h0};
        host_rd_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        host_rd_en = 1'b0;
        check("R9 same-cycle read returns prior capture", host_rd_data, 32'(exp_rows[16]));
        rd(v);
        check("R9 next read returns window", v, 32'(exp_win));
        check_state("R2 final state");

        finish_run();
    end

endmodule